// File: doc/BRIEF.md
# Operand Forwarding and Hazard Stall Unit

This block holds the hazard logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register numbers in decode and in execute, and at the destination number, write-enable and load flag of the instructions in execute, memory and writeback. From these it picks where each ALU input comes from. It also raises a front-end freeze, which holds the PC and the fetch/decode register, and a bubble request, which loads an all-control-off slot into the decode/execute register. The older stages keep moving during a stall.

The register file is taken to write in the first half of a cycle and read in the second. So a result in writeback is already visible to the instruction in decode, and no bypass is needed for that distance. The parameter `FWD_EN` picks one of two schemes. With forwarding, only a load directly ahead of its consumer costs a cycle. Without forwarding, every consumer waits in decode until its producer reaches writeback. This makes the cost of pure stalling easy to measure against forwarding.

Top module: `fwdStallUnit`

## Requirements
- R1: Select encoding for `fwdSelA`/`fwdSelB`: 0 takes the value read from the register file, 1 takes the memory-stage ALU result, 2 takes the writeback value. With no instruction writing (all write-enables low) both selects are 0 and the freeze and bubble outputs are low.
- R2: With forwarding, an ALU result one instruction ahead is routed with select 1 and no stall. Each operand is resolved on its own, including a store's base register and a consumer that names the same producer register in both operands.
- R3: With forwarding, a producer two instructions ahead (in writeback when the consumer executes) gives select 2. A producer three or more ahead needs no stall and no bypass (select 0), because the register file writes before it is read.
- R4: With forwarding, a load directly followed by a consumer of its result causes exactly one stall cycle. The loaded value then reaches the consumer through select 2.
- R5: When the memory-stage and the writeback-stage instructions both write the register a source needs, the memory-stage (younger) value is selected.
- R6: Register 0 never causes a stall and is never forwarded.
- R7: An instruction whose write-enable is low (a store, or a bubble) never causes a stall or a forward, whatever its destination field holds.
- R8: With forwarding disabled, both selects stay 0, and a consumer stalls while a matching producer sits in execute or memory. The penalty is two cycles for an adjacent producer, one at distance two and none at distance three.
- R9: Freeze and bubble are asserted together in every cycle. Register values produced by the pipeline match sequential execution in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| idRs1 | input | REG_W | First source register of the decode instruction |
| idRs2 | input | REG_W | Second source register of the decode instruction |
| exRs1 | input | REG_W | First source register of the execute instruction |
| exRs2 | input | REG_W | Second source register of the execute instruction |
| exRd | input | REG_W | Destination of the execute instruction |
| exWe | input | 1 | Execute instruction writes a register |
| exLoad | input | 1 | Execute instruction is a load |
| memRd | input | REG_W | Destination of the memory-stage instruction |
| memWe | input | 1 | Memory-stage instruction writes a register |
| memLoad | input | 1 | Memory-stage instruction is a load |
| wbRd | input | REG_W | Destination of the writeback instruction |
| wbWe | input | 1 | Writeback instruction writes a register |
| fwdSelA | output | 2 | Source select for ALU input A (encoding in R1) |
| fwdSelB | output | 2 | Source select for ALU input B (encoding in R1) |
| stallFront | output | 1 | Hold PC and fetch/decode register |
| bubbleEx | output | 1 | Load an empty slot into decode/execute |

## Verification
The assertions assume that the unit sits inside a pipeline that obeys its strobes. After a stall the execute slot must hold a bubble with write-enable low, and the producer that was in execute must have moved on to the memory stage. Destination and source fields of empty slots must read as zero, with their enables low. The bench meets these assumptions by driving every input from a cycle-level pipeline model that uses the unit's own freeze and bubble outputs to advance. That model replays short dependent programs and compares the final register contents with a sequential reference.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_REG = 2'd0,
    SEL_MEM = 2'd1,
    SEL_WB  = 2'd2
  } opSel_e;

  typedef struct packed {
    logic freezeFront;
    logic bubbleEx;
  } hazStrobe_t;
endpackage

// File: rtl/fwdSelectPath.sv
`timescale 1ns/1ps
module fwdSelectPath
  import fwd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter bit FWD_EN  = 1'b1,
  parameter int NUM_SRC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] exSrc [NUM_SRC],
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic             memLoad,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbWe,
  output opSel_e           srcSel [NUM_SRC]
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    opSel_e sel;
    if (FWD_EN) begin : gBypass
      logic liveSrc;
      logic memHit;
      logic wbHit;
      assign liveSrc = (exSrc[g] != ZERO_REG);
      // ALU result in memory stage; a load's data is not ready there
      assign memHit  = memWe && !memLoad && (memRd == exSrc[g]);
      assign wbHit   = wbWe && (wbRd == exSrc[g]);
      always_comb begin
        sel = SEL_REG;
        if (liveSrc && memHit)     sel = SEL_MEM;  // younger producer first
        else if (liveSrc && wbHit) sel = SEL_WB;
      end

      p_no_zero_fwd_r6: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel[g] != SEL_REG) |-> (exSrc[g] != ZERO_REG));
      p_mem_writer_r7: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel[g] == SEL_MEM) |-> (memWe && !memLoad));
      p_wb_writer_r5: assert property (@(posedge clk) disable iff (!rstN)
        (srcSel[g] == SEL_WB) |-> (wbWe && wbRd == exSrc[g]));
    end else begin : gNoBypass
      assign sel = SEL_REG;
    end
    assign srcSel[g] = sel;
  end
endmodule

// File: rtl/stallControl.sv
`timescale 1ns/1ps
module stallControl
  import fwd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter bit FWD_EN  = 1'b1,
  parameter int NUM_SRC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] idSrc [NUM_SRC],
  input  logic [REG_W-1:0] exRd,
  input  logic             exWe,
  input  logic             exLoad,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  output hazStrobe_t       strobe
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;
  // longest run of back-to-back stall cycles one dependency may cause
  localparam int MAX_RUN = FWD_EN ? 1 : 2;

  logic [NUM_SRC-1:0] srcLive;
  logic [NUM_SRC-1:0] hitEx;
  logic               needStall;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gCmp
    assign srcLive[g] = (idSrc[g] != ZERO_REG);
    assign hitEx[g]   = srcLive[g] && exWe && (exRd == idSrc[g]);
  end

  if (FWD_EN) begin : gLoadUse
    // only a load right ahead cannot be bypassed in time
    assign needStall = exLoad && (|hitEx);
  end else begin : gWaitWb
    logic [NUM_SRC-1:0] hitMem;
    for (genvar g = 0; g < NUM_SRC; g++) begin : gMem
      assign hitMem[g] = srcLive[g] && memWe && (memRd == idSrc[g]);
    end
    // writeback producer is covered by write-first register file
    assign needStall = |(hitEx | hitMem);
  end

  assign strobe.freezeFront = needStall;
  assign strobe.bubbleEx    = needStall;

  logic [1:0] stallRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    stallRun <= '0;
    else if (!strobe.freezeFront) stallRun <= '0;
    else if (stallRun != 2'd3)    stallRun <= stallRun + 2'd1;
  end

  // R4 (one cycle with forwarding) and R8 (two without)
  p_stall_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(stallRun) <= MAX_RUN));
  p_stall_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freezeFront |-> (|srcLive));
  p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freezeFront |-> (exWe || memWe));
  p_bubble_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bubbleEx |=> !exWe);
  p_producer_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.freezeFront && exWe) |=> (memWe && memRd == $past(exRd)));
endmodule

// File: rtl/fwdStallUnit.sv
`timescale 1ns/1ps
module fwdStallUnit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] idRs1,
  input  logic [REG_W-1:0] idRs2,
  input  logic [REG_W-1:0] exRs1,
  input  logic [REG_W-1:0] exRs2,
  input  logic [REG_W-1:0] exRd,
  input  logic             exWe,
  input  logic             exLoad,
  input  logic [REG_W-1:0] memRd,
  input  logic             memWe,
  input  logic             memLoad,
  input  logic [REG_W-1:0] wbRd,
  input  logic             wbWe,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             stallFront,
  output logic             bubbleEx
);
  localparam int NUM_SRC = 2;

  logic [REG_W-1:0] idSrc [NUM_SRC];
  logic [REG_W-1:0] exSrc [NUM_SRC];
  opSel_e           srcSel [NUM_SRC];
  hazStrobe_t       strobe;

  assign idSrc[0] = idRs1;
  assign idSrc[1] = idRs2;
  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;

  fwdSelectPath #(.REG_W(REG_W), .FWD_EN(FWD_EN), .NUM_SRC(NUM_SRC)) uPath (
    .clk(clk), .rstN(rstN), .exSrc(exSrc),
    .memRd(memRd), .memWe(memWe), .memLoad(memLoad),
    .wbRd(wbRd), .wbWe(wbWe), .srcSel(srcSel)
  );

  stallControl #(.REG_W(REG_W), .FWD_EN(FWD_EN), .NUM_SRC(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN), .idSrc(idSrc),
    .exRd(exRd), .exWe(exWe), .exLoad(exLoad),
    .memRd(memRd), .memWe(memWe), .strobe(strobe)
  );

  assign fwdSelA    = srcSel[0];
  assign fwdSelB    = srcSel[1];
  assign stallFront = strobe.freezeFront;
  assign bubbleEx   = strobe.bubbleEx;
endmodule

// File: tb/tb_fwdStallUnit.sv
`timescale 1ns/1ps
package tb_pkg;
  typedef struct packed {
    logic       valid;
    logic       we;
    logic       isLoad;
    logic [3:0] idx;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
  } tbInstr_t;
endpackage

// cycle-level pipeline that obeys the unit's strobes
module tbPipe
  import tb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stall,
  input  logic       bubble,
  input  logic [1:0] selA,
  input  logic [1:0] selB,
  output logic [4:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd,
  output logic       exWe, exLoad, memWe, memLoad, wbWe
);
  tbInstr_t    prog [16];
  int          progLen = 0;
  logic        run = 1'b0;
  int          pc = 0;
  int          stallCount = 0;
  int          splitCount = 0;
  logic [1:0]  obsA [16];
  logic [1:0]  obsB [16];
  int unsigned rf [32];
  tbInstr_t    idI = '0, exI = '0, memI = '0, wbI = '0;
  int unsigned exA = 0, exB = 0, memRes = 0, wbVal = 0;
  logic        sStall = 1'b0, sBubble = 1'b0;
  logic [1:0]  sA = 2'd0, sB = 2'd0;

  always @(negedge clk) begin
    sStall  = stall;
    sBubble = bubble;
    sA      = selA;
    sB      = selB;
  end

  assign idRs1   = idI.valid ? idI.rs1 : 5'd0;
  assign idRs2   = idI.valid ? idI.rs2 : 5'd0;
  assign exRs1   = exI.valid ? exI.rs1 : 5'd0;
  assign exRs2   = exI.valid ? exI.rs2 : 5'd0;
  assign exRd    = exI.valid ? exI.rd : 5'd0;
  assign exWe    = exI.valid && exI.we;
  assign exLoad  = exI.valid && exI.isLoad;
  assign memRd   = memI.valid ? memI.rd : 5'd0;
  assign memWe   = memI.valid && memI.we;
  assign memLoad = memI.valid && memI.isLoad;
  assign wbRd    = wbI.valid ? wbI.rd : 5'd0;
  assign wbWe    = wbI.valid && wbI.we;

  task automatic startProg();
    idI = '0; exI = '0; memI = '0; wbI = '0;
    pc = 0; stallCount = 0; splitCount = 0;
    for (int i = 0; i < 16; i++) begin obsA[i] = 2'd3; obsB[i] = 2'd3; end
    run = 1'b1;
  endtask

  always @(posedge clk) begin
    int unsigned opA, opB, exOut, memOut, rdA, rdB;
    if (!rstN) begin
      idI = '0; exI = '0; memI = '0; wbI = '0;
    end else if (run) begin
      opA = (sA == 2'd1) ? memRes : (sA == 2'd2) ? wbVal : exA;
      opB = (sB == 2'd1) ? memRes : (sB == 2'd2) ? wbVal : exB;
      if (exI.valid) begin obsA[exI.idx] = sA; obsB[exI.idx] = sB; end
      exOut  = exI.isLoad ? opA : opA + opB;
      memOut = memI.isLoad ? memRes + 7 : memRes;
      if (wbI.valid && wbI.we && wbI.rd != 5'd0) rf[wbI.rd] = wbVal;
      rdA = rf[idI.rs1];
      rdB = rf[idI.rs2];
      if (sStall != sBubble) splitCount++;
      wbI = memI; wbVal = memOut;
      memI = exI; memRes = exOut;
      if (sStall) begin
        exI = '0;
        stallCount++;
      end else begin
        exI = idI; exA = rdA; exB = rdB;
        if (pc < progLen) begin idI = prog[pc]; pc++; end
        else idI = '0;
      end
      if (pc >= progLen && !idI.valid && !exI.valid && !memI.valid && !wbI.valid)
        run = 1'b0;
    end
  end
endmodule

module tb_fwdStallUnit;
  import tb_pkg::*;

  localparam logic [1:0] SR = 2'd0;
  localparam logic [1:0] SM = 2'd1;
  localparam logic [1:0] SW = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] aIdRs1, aIdRs2, aExRs1, aExRs2, aExRd, aMemRd, aWbRd;
  logic       aExWe, aExLoad, aMemWe, aMemLoad, aWbWe, aStall, aBubble;
  logic [1:0] aSelA, aSelB;
  logic [4:0] bIdRs1, bIdRs2, bExRs1, bExRs2, bExRd, bMemRd, bWbRd;
  logic       bExWe, bExLoad, bMemWe, bMemLoad, bWbWe, bStall, bBubble;
  logic [1:0] bSelA, bSelB;

  fwdStallUnit #(.REG_W(5), .FWD_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .idRs1(aIdRs1), .idRs2(aIdRs2),
    .exRs1(aExRs1), .exRs2(aExRs2), .exRd(aExRd), .exWe(aExWe), .exLoad(aExLoad),
    .memRd(aMemRd), .memWe(aMemWe), .memLoad(aMemLoad), .wbRd(aWbRd), .wbWe(aWbWe),
    .fwdSelA(aSelA), .fwdSelB(aSelB), .stallFront(aStall), .bubbleEx(aBubble));

  fwdStallUnit #(.REG_W(5), .FWD_EN(1'b0)) dutNoFwd (
    .clk(clk), .rstN(rstN), .idRs1(bIdRs1), .idRs2(bIdRs2),
    .exRs1(bExRs1), .exRs2(bExRs2), .exRd(bExRd), .exWe(bExWe), .exLoad(bExLoad),
    .memRd(bMemRd), .memWe(bMemWe), .memLoad(bMemLoad), .wbRd(bWbRd), .wbWe(bWbWe),
    .fwdSelA(bSelA), .fwdSelB(bSelB), .stallFront(bStall), .bubbleEx(bBubble));

  tbPipe modA (
    .clk(clk), .rstN(rstN), .stall(aStall), .bubble(aBubble), .selA(aSelA), .selB(aSelB),
    .idRs1(aIdRs1), .idRs2(aIdRs2), .exRs1(aExRs1), .exRs2(aExRs2), .exRd(aExRd),
    .memRd(aMemRd), .wbRd(aWbRd), .exWe(aExWe), .exLoad(aExLoad), .memWe(aMemWe),
    .memLoad(aMemLoad), .wbWe(aWbWe));

  tbPipe modB (
    .clk(clk), .rstN(rstN), .stall(bStall), .bubble(bBubble), .selA(bSelA), .selB(bSelB),
    .idRs1(bIdRs1), .idRs2(bIdRs2), .exRs1(bExRs1), .exRs2(bExRs2), .exRd(bExRd),
    .memRd(bMemRd), .wbRd(bWbRd), .exWe(bExWe), .exLoad(bExLoad), .memWe(bMemWe),
    .memLoad(bMemLoad), .wbWe(bWbWe));

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  tbInstr_t progBuf [16];
  int progN = 0;
  int unsigned gold [32];

  task automatic checkEq(string req, string what, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  function automatic void addInstr(int rd, int rs1, int rs2, bit we, bit ld);
    progBuf[progN] = '{valid: 1'b1, we: we, isLoad: ld, idx: 4'(progN),
                       rd: 5'(rd), rs1: 5'(rs1), rs2: 5'(rs2)};
    progN++;
  endfunction
  function automatic void alu(int rd, int a, int b); addInstr(rd, a, b, 1'b1, 1'b0); endfunction
  function automatic void load(int rd, int base);    addInstr(rd, base, 0, 1'b1, 1'b1); endfunction
  function automatic void store(int base, int src, int rdField);
    addInstr(rdField, base, src, 1'b0, 1'b0);
  endfunction

  task automatic runProg(string req);
    int waited = 0;
    int badA = 0;
    int badB = 0;
    for (int r = 0; r < 32; r++) gold[r] = (r == 0) ? 0 : r * 3 + 1;
    for (int i = 0; i < progN; i++) begin
      int unsigned a = gold[progBuf[i].rs1];
      int unsigned b = gold[progBuf[i].rs2];
      if (progBuf[i].we && progBuf[i].rd != 5'd0)
        gold[progBuf[i].rd] = progBuf[i].isLoad ? a + 7 : a + b;
    end
    @(negedge clk);
    for (int i = 0; i < progN; i++) begin modA.prog[i] = progBuf[i]; modB.prog[i] = progBuf[i]; end
    modA.progLen = progN;
    modB.progLen = progN;
    for (int r = 0; r < 32; r++) begin
      modA.rf[r] = (r == 0) ? 0 : r * 3 + 1;
      modB.rf[r] = (r == 0) ? 0 : r * 3 + 1;
    end
    modA.startProg();
    modB.startProg();
    while ((modA.run || modB.run) && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    checkEq(req, "program drains", (waited < 300) ? 1 : 0, 1);
    for (int r = 0; r < 32; r++) begin
      if (modA.rf[r] != gold[r]) badA++;
      if (modB.rf[r] != gold[r]) badB++;
    end
    checkEq("R9", "forwarding mode register mismatches", badA, 0);
    checkEq("R9", "stall-only mode register mismatches", badB, 0);
    checkEq("R9", "freeze/bubble disagreement cycles", modA.splitCount + modB.splitCount, 0);
  endtask

  task automatic testIdle();
    @(negedge clk);
    checkEq("R1", "idle stall fwd", int'(aStall), 0);
    checkEq("R1", "idle bubble fwd", int'(aBubble), 0);
    checkEq("R1", "idle selA fwd", int'(aSelA), int'(SR));
    checkEq("R1", "idle selB fwd", int'(aSelB), int'(SR));
    checkEq("R1", "idle stall no-fwd", int'(bStall), 0);
  endtask

  task automatic testAluChain();
    progN = 0;
    alu(1, 2, 3);
    alu(4, 1, 1);
    runProg("R2");
    checkEq("R2", "adjacent ALU stalls", modA.stallCount, 0);
    checkEq("R2", "adjacent selA", int'(modA.obsA[1]), int'(SM));
    checkEq("R2", "adjacent selB same producer", int'(modA.obsB[1]), int'(SM));
    checkEq("R8", "adjacent ALU stalls no-fwd", modB.stallCount, 2);
    checkEq("R8", "no-fwd selA", int'(modB.obsA[1]), int'(SR));
  endtask

  task automatic testLoadUse();
    progN = 0;
    load(5, 1);
    alu(6, 5, 2);
    runProg("R4");
    checkEq("R4", "load-use stalls", modA.stallCount, 1);
    checkEq("R4", "load-use selA", int'(modA.obsA[1]), int'(SW));
    checkEq("R4", "load-use selB unrelated", int'(modA.obsB[1]), int'(SR));
    checkEq("R8", "load-use stalls no-fwd", modB.stallCount, 2);
  endtask

  task automatic testDistance();
    progN = 0;
    alu(1, 2, 3);
    alu(10, 4, 5);
    alu(11, 6, 1);
    runProg("R3");
    checkEq("R3", "distance two stalls", modA.stallCount, 0);
    checkEq("R3", "distance two selB", int'(modA.obsB[2]), int'(SW));
    checkEq("R8", "distance two stalls no-fwd", modB.stallCount, 1);
    progN = 0;
    alu(1, 2, 3);
    alu(10, 4, 5);
    alu(11, 4, 5);
    alu(12, 1, 6);
    runProg("R3");
    checkEq("R3", "distance three selA", int'(modA.obsA[3]), int'(SR));
    checkEq("R3", "distance three stalls", modA.stallCount, 0);
    checkEq("R8", "distance three stalls no-fwd", modB.stallCount, 0);
  endtask

  task automatic testYoungerWins();
    progN = 0;
    alu(1, 2, 3);
    alu(1, 4, 5);
    alu(7, 1, 0);
    runProg("R5");
    checkEq("R5", "double writer selA", int'(modA.obsA[2]), int'(SM));
    checkEq("R5", "double writer stalls", modA.stallCount, 0);
    checkEq("R8", "double writer stalls no-fwd", modB.stallCount, 2);
  endtask

  task automatic testRegZero();
    progN = 0;
    alu(0, 2, 3);
    alu(8, 0, 0);
    load(0, 1);
    alu(9, 0, 2);
    runProg("R6");
    checkEq("R6", "r0 stalls fwd", modA.stallCount, 0);
    checkEq("R6", "r0 stalls no-fwd", modB.stallCount, 0);
    checkEq("R6", "r0 selA", int'(modA.obsA[1]), int'(SR));
    checkEq("R6", "r0 selB", int'(modA.obsB[1]), int'(SR));
    checkEq("R6", "r0 after load selA", int'(modA.obsA[3]), int'(SR));
  endtask

  task automatic testWriteDisabled();
    progN = 0;
    store(9, 3, 9);
    alu(13, 9, 9);
    alu(9, 1, 2);
    store(9, 9, 9);
    alu(14, 9, 0);
    runProg("R7");
    checkEq("R7", "store dest ignored selA", int'(modA.obsA[1]), int'(SR));
    checkEq("R7", "store dest ignored selB", int'(modA.obsB[1]), int'(SR));
    checkEq("R2", "store base selA", int'(modA.obsA[3]), int'(SM));
    checkEq("R2", "store data selB", int'(modA.obsB[3]), int'(SM));
    checkEq("R7", "store in memory skipped", int'(modA.obsA[4]), int'(SW));
    checkEq("R7", "stalls fwd", modA.stallCount, 0);
    checkEq("R8", "stalls no-fwd", modB.stallCount, 2);
  endtask

  task automatic testLoadChain();
    progN = 0;
    load(5, 1);
    load(6, 5);
    alu(7, 6, 5);
    runProg("R4");
    checkEq("R4", "load chain stalls", modA.stallCount, 2);
    checkEq("R4", "load base selA", int'(modA.obsA[1]), int'(SW));
    checkEq("R4", "chain consumer selA", int'(modA.obsA[2]), int'(SW));
    checkEq("R3", "old load selB", int'(modA.obsB[2]), int'(SR));
    checkEq("R8", "load chain stalls no-fwd", modB.stallCount, 4);
  endtask

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected done");
      printSummary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testIdle();
    testAluChain();
    testLoadUse();
    testDistance();
    testYoungerWins();
    testRegZero();
    testWriteDisabled();
    testLoadChain();
    testIdle();
    finished = 1'b1;
    printSummary();
    $finish;
  end
endmodule